// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps every issued instruction in program order inside a small circular queue. Each entry holds the instruction's result until the instruction is no longer speculative, and then retires it from the oldest end. The issue stage asks for an entry. The entry number it gets back serves as the result tag for that instruction. Execution units later post a value against that tag, and waiting instructions can fetch the value through a tag lookup port before the result is retired. A small table maps each architectural register to the tag of its youngest pending producer, so that issue logic can tell whether a source register must be read from the buffer.

Up to two instructions retire per clock. A register operation retires as a register-file write and a store retires as a memory write. A branch that was predicted correctly simply leaves the buffer. Two events at the oldest entry empty the whole buffer: a mispredicted branch, which also restarts fetch at the branch's correct target, and a recorded exception. An exception is therefore only reported once all older instructions have retired, and an exception on an entry that a flush removes is never reported.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty. Allocation is granted with tag 0, no retirement, flush or exception output is active, no register shows a pending producer, and lookups report not ready.
- R2: Each granted allocation returns the next tag in sequence, wrapping modulo the depth (8). Allocation is refused (grant low) while all 8 entries are occupied. Kind encoding: 0 register operation, 1 store, 2 branch.
- R3: A result posted for an occupied tag marks it ready. From the next cycle until retirement the lookup port returns that value with ready high, and before the result it returns ready low.
- R4: Nothing retires while the oldest entry lacks a result, even if younger entries have theirs.
- R5: A retiring register operation drives a register write with the low 4 bits of its destination as register number and its result as data. A store drives a memory write with its destination as address and its result as data. A correctly predicted branch drives no write.
- R6: Up to two entries retire per cycle, oldest in slot 0. Slot 1 retires only if slot 0 retires normally in the same cycle and slot 1 is neither an exception nor a mispredicted branch.
- R7: A mispredicted branch at the oldest position pulses flush with its correct target, empties the buffer and restarts tags at 0.
- R8: An exception is reported only when its entry is oldest and ready. It drives no write, empties the buffer, and is never reported if an older flush removed the entry.
- R9: Allocating a register operation marks its destination register pending with the new tag. A retiring register write clears that mark only if the mark still names the retiring tag. Any flush clears all marks.
- R10: A result or branch resolution posted for an unoccupied tag has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_req_i | input | 1 | Request a new entry |
| alloc_kind_i | input | 2 | Instruction kind (0 register op, 1 store, 2 branch) |
| alloc_dest_i | input | 16 | Destination register number or store address |
| alloc_gnt_o | output | 1 | Allocation accepted this cycle |
| alloc_tag_o | output | 3 | Tag of the entry being allocated |
| res_valid_i | input | 1 | Result write strobe |
| res_tag_i | input | 3 | Tag receiving the result |
| res_value_i | input | 32 | Result value or store data |
| res_exc_i | input | 1 | Result carries an exception |
| br_valid_i | input | 1 | Branch resolution strobe |
| br_tag_i | input | 3 | Tag of the resolved branch |
| br_mispred_i | input | 1 | Branch was mispredicted |
| br_target_i | input | 32 | Correct successor address |
| look_tag_i | input | 3 | Tag to look up |
| look_ready_o | output | 1 | Looked-up entry holds a result |
| look_value_o | output | 32 | Looked-up value |
| src_reg_i | input | 4 | Register to query for a pending producer |
| src_busy_o | output | 1 | Register has a pending producer |
| src_tag_o | output | 3 | Tag of that producer |
| cm_reg_we_o | output | 2 | Register write per retire slot |
| cm_reg_addr_o | output | 2x4 | Register number per slot |
| cm_reg_data_o | output | 2x32 | Register data per slot |
| cm_st_we_o | output | 2 | Memory write per retire slot |
| cm_st_addr_o | output | 2x16 | Store address per slot |
| cm_st_data_o | output | 2x32 | Store data per slot |
| flush_o | output | 1 | Mispredicted branch retired, buffer emptied |
| redirect_o | output | 32 | Fetch restart address with flush |
| exc_o | output | 1 | Exception taken at the oldest entry |

## Verification
A stuck or misplaced head pointer shows up as retirements that come out of order, carry the wrong destination, or never come, and every retirement is checked against an ordered list of expected events. A wrong ready bit or stale tag mapping shows up on the lookup and pending-register ports in the cycle after the result or retirement. Flush and exception faults appear as missing, extra or early flush and exception pulses, and as a wrong first tag after recovery, all compared at the first cycle they can occur. Slot-1 gating is probed by placing a faulting or mispredicted entry directly behind a retiring one.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_REG    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2
  } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [1:0]       nret_i,
  input  logic             flush_i,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_q + TAG_W'(nret_i);
      tail_q  <= tail_q + TAG_W'(alloc_i);
      count_q <= count_q + CNT_W'(alloc_i) - CNT_W'(nret_i);
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = count_q;
  assign full_o  = (count_q == CNT_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH)); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0 && head_q == '0)); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CNT_W'(nret_i) <= count_q); // R6
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
(
  input  logic [1:0] valid_i,
  input  logic [1:0] ready_i,
  input  logic [1:0] exc_i,
  input  logic [1:0] mispred_i,
  input  rob_kind_e  kind0_i,
  input  rob_kind_e  kind1_i,
  output logic [1:0] take_o,
  output logic       kill_o,
  output logic       trap_o
);
  logic       done0, done1;
  logic [1:0] bad;

  always_comb begin
    done0  = valid_i[0] & ready_i[0];
    done1  = valid_i[1] & ready_i[1];
    bad[0] = exc_i[0] | ((kind0_i == K_BRANCH) & mispred_i[0]);
    bad[1] = exc_i[1] | ((kind1_i == K_BRANCH) & mispred_i[1]);
    // exception outranks a mispredict recorded on the same entry
    trap_o    = done0 & exc_i[0];
    kill_o    = done0 & ~exc_i[0] & (kind0_i == K_BRANCH) & mispred_i[0];
    take_o[0] = done0 & ~bad[0];
    take_o[1] = take_o[0] & done1 & ~bad[1];
  end
endmodule

// File: rtl/rob_rename.sv
module rob_rename #(
  parameter int NREG  = 16,
  parameter int DEPTH = 8,
  localparam int REG_W = $clog2(NREG),
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  set_i,
  input  logic [REG_W-1:0]      set_reg_i,
  input  logic [TAG_W-1:0]      set_tag_i,
  input  logic [1:0]            clr_i,
  input  logic [1:0][REG_W-1:0] clr_reg_i,
  input  logic [1:0][TAG_W-1:0] clr_tag_i,
  input  logic                  flush_i,
  input  logic [REG_W-1:0]      query_reg_i,
  output logic                  busy_o,
  output logic [TAG_W-1:0]      tag_o
);
  logic [NREG-1:0]             busy_q;
  logic [NREG-1:0][TAG_W-1:0]  tag_q;

  for (genvar r = 0; r < NREG; r++) begin : g_map
    logic hit_clr;
    always_comb begin
      hit_clr = 1'b0;
      for (int s = 0; s < 2; s++) begin
        if (clr_i[s] && clr_reg_i[s] == REG_W'(r) && tag_q[r] == clr_tag_i[s])
          hit_clr = 1'b1;
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q[r] <= 1'b0;
        tag_q[r]  <= '0;
      end else if (flush_i) begin
        busy_q[r] <= 1'b0;
      end else if (set_i && set_reg_i == REG_W'(r)) begin
        busy_q[r] <= 1'b1;
        tag_q[r]  <= set_tag_i;
      end else if (hit_clr) begin
        busy_q[r] <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q[query_reg_i];
  assign tag_o  = tag_q[query_reg_i];

  AST_MAP_FLUSHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (busy_q == '0)); // R9
  AST_MAP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !flush_i) |=> (busy_q[$past(set_reg_i)] && tag_q[$past(set_reg_i)] == $past(set_tag_i))); // R9
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 16,
  parameter int NREG   = 16,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int REG_W = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   alloc_req_i,
  input  logic [1:0]             alloc_kind_i,
  input  logic [DEST_W-1:0]      alloc_dest_i,
  output logic                   alloc_gnt_o,
  output logic [TAG_W-1:0]       alloc_tag_o,
  input  logic                   res_valid_i,
  input  logic [TAG_W-1:0]       res_tag_i,
  input  logic [DATA_W-1:0]      res_value_i,
  input  logic                   res_exc_i,
  input  logic                   br_valid_i,
  input  logic [TAG_W-1:0]       br_tag_i,
  input  logic                   br_mispred_i,
  input  logic [DATA_W-1:0]      br_target_i,
  input  logic [TAG_W-1:0]       look_tag_i,
  output logic                   look_ready_o,
  output logic [DATA_W-1:0]      look_value_o,
  input  logic [REG_W-1:0]       src_reg_i,
  output logic                   src_busy_o,
  output logic [TAG_W-1:0]       src_tag_o,
  output logic [1:0]             cm_reg_we_o,
  output logic [1:0][REG_W-1:0]  cm_reg_addr_o,
  output logic [1:0][DATA_W-1:0] cm_reg_data_o,
  output logic [1:0]             cm_st_we_o,
  output logic [1:0][DEST_W-1:0] cm_st_addr_o,
  output logic [1:0][DATA_W-1:0] cm_st_data_o,
  output logic                   flush_o,
  output logic [DATA_W-1:0]      redirect_o,
  output logic                   exc_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]              valid_q, ready_q, exc_q, misp_q;
  rob_kind_e                     kind_q  [DEPTH];
  logic [DEPTH-1:0][DEST_W-1:0]  dest_q;
  logic [DEPTH-1:0][DATA_W-1:0]  value_q;

  logic [TAG_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             full, alloc_fire, kill, trap, flush_all;
  logic [1:0]       take, nret;
  logic [1:0][TAG_W-1:0] idx;
  rob_kind_e        new_kind;

  assign idx[0]     = head;
  assign idx[1]     = head + TAG_W'(1);
  assign new_kind   = rob_kind_e'(alloc_kind_i);
  assign flush_all  = kill | trap;
  assign alloc_gnt_o = ~full & ~flush_all;
  assign alloc_tag_o = tail;
  assign alloc_fire = alloc_req_i & alloc_gnt_o;
  assign nret       = {1'b0, take[0]} + {1'b0, take[1]};

  rob_ptrs #(.DEPTH(DEPTH)) i_ptrs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (alloc_fire),
    .nret_i  (nret),
    .flush_i (flush_all),
    .head_o  (head),
    .tail_o  (tail),
    .count_o (count),
    .full_o  (full)
  );

  rob_retire i_retire (
    .valid_i   ({valid_q[idx[1]], valid_q[idx[0]]}),
    .ready_i   ({ready_q[idx[1]], ready_q[idx[0]]}),
    .exc_i     ({exc_q[idx[1]],   exc_q[idx[0]]}),
    .mispred_i ({misp_q[idx[1]],  misp_q[idx[0]]}),
    .kind0_i   (kind_q[idx[0]]),
    .kind1_i   (kind_q[idx[1]]),
    .take_o    (take),
    .kill_o    (kill),
    .trap_o    (trap)
  );

  // entry storage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ready_q <= '0;
      exc_q   <= '0;
      misp_q  <= '0;
      dest_q  <= '0;
      value_q <= '0;
      for (int i = 0; i < DEPTH; i++) kind_q[i] <= K_REG;
    end else if (flush_all) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_fire && tail == TAG_W'(i)) begin
          valid_q[i] <= 1'b1;
          ready_q[i] <= 1'b0;
          exc_q[i]   <= 1'b0;
          misp_q[i]  <= 1'b0;
          kind_q[i]  <= new_kind;
          dest_q[i]  <= alloc_dest_i;
        end else begin
          if ((take[0] && idx[0] == TAG_W'(i)) || (take[1] && idx[1] == TAG_W'(i)))
            valid_q[i] <= 1'b0;
          if (valid_q[i] && res_valid_i && res_tag_i == TAG_W'(i)) begin
            ready_q[i] <= 1'b1;
            exc_q[i]   <= res_exc_i;
            value_q[i] <= res_value_i;
          end
          if (valid_q[i] && br_valid_i && br_tag_i == TAG_W'(i)) begin
            ready_q[i] <= 1'b1;
            misp_q[i]  <= br_mispred_i;
            value_q[i] <= br_target_i;
          end
        end
      end
    end
  end

  // retire outputs
  for (genvar s = 0; s < 2; s++) begin : g_slot
    assign cm_reg_we_o[s]   = take[s] & (kind_q[idx[s]] == K_REG);
    assign cm_reg_addr_o[s] = dest_q[idx[s]][REG_W-1:0];
    assign cm_reg_data_o[s] = value_q[idx[s]];
    assign cm_st_we_o[s]    = take[s] & (kind_q[idx[s]] == K_STORE);
    assign cm_st_addr_o[s]  = dest_q[idx[s]];
    assign cm_st_data_o[s]  = value_q[idx[s]];
  end

  assign flush_o    = kill;
  assign exc_o      = trap;
  assign redirect_o = value_q[idx[0]];

  assign look_ready_o = valid_q[look_tag_i] & ready_q[look_tag_i];
  assign look_value_o = value_q[look_tag_i];

  rob_rename #(.NREG(NREG), .DEPTH(DEPTH)) i_rename (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (alloc_fire && new_kind == K_REG),
    .set_reg_i   (alloc_dest_i[REG_W-1:0]),
    .set_tag_i   (tail),
    .clr_i       (cm_reg_we_o),
    .clr_reg_i   (cm_reg_addr_o),
    .clr_tag_i   (idx),
    .flush_i     (flush_all),
    .query_reg_i (src_reg_i),
    .busy_o      (src_busy_o),
    .tag_o       (src_tag_o)
  );

  AST_FULL_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == CNT_W'(DEPTH)) |-> !alloc_gnt_o); // R2
  AST_ONE_EVENT_SLOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cm_reg_we_o[0], cm_st_we_o[0], flush_o, exc_o})); // R5
  AST_SLOT1_BEHIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cm_reg_we_o[1] | cm_st_we_o[1]) |-> (cm_reg_we_o[0] | cm_st_we_o[0] | (kind_q[idx[0]] == K_BRANCH))); // R6
  AST_RETIRE_LEAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cm_reg_we_o[0] | cm_st_we_o[0]) |=> !valid_q[$past(idx[0])] || (tail == $past(idx[0]) + TAG_W'(1) && $past(alloc_fire))); // R5
  AST_WAIT_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o | flush_o) |-> (valid_q[head] & ready_q[head])); // R8
endmodule

// File: tb/test_reorder_buf.sv
module test_reorder_buf;
  localparam int DATA_W = 32, DEST_W = 16, REG_W = 4, TAG_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic alloc_req = 0; logic [1:0] alloc_kind = 0; logic [DEST_W-1:0] alloc_dest = 0;
  logic alloc_gnt; logic [TAG_W-1:0] alloc_tag;
  logic res_valid = 0; logic [TAG_W-1:0] res_tag = 0; logic [DATA_W-1:0] res_value = 0; logic res_exc = 0;
  logic br_valid = 0; logic [TAG_W-1:0] br_tag = 0; logic br_mispred = 0; logic [DATA_W-1:0] br_target = 0;
  logic [TAG_W-1:0] look_tag = 0; logic look_ready; logic [DATA_W-1:0] look_value;
  logic [REG_W-1:0] src_reg = 0; logic src_busy; logic [TAG_W-1:0] src_tag;
  logic [1:0] cm_reg_we, cm_st_we;
  logic [1:0][REG_W-1:0] cm_reg_addr; logic [1:0][DATA_W-1:0] cm_reg_data;
  logic [1:0][DEST_W-1:0] cm_st_addr; logic [1:0][DATA_W-1:0] cm_st_data;
  logic flush, exc; logic [DATA_W-1:0] redirect;

  reorder_buf i_reorder_buf (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_req_i(alloc_req), .alloc_kind_i(alloc_kind), .alloc_dest_i(alloc_dest),
    .alloc_gnt_o(alloc_gnt), .alloc_tag_o(alloc_tag),
    .res_valid_i(res_valid), .res_tag_i(res_tag), .res_value_i(res_value), .res_exc_i(res_exc),
    .br_valid_i(br_valid), .br_tag_i(br_tag), .br_mispred_i(br_mispred), .br_target_i(br_target),
    .look_tag_i(look_tag), .look_ready_o(look_ready), .look_value_o(look_value),
    .src_reg_i(src_reg), .src_busy_o(src_busy), .src_tag_o(src_tag),
    .cm_reg_we_o(cm_reg_we), .cm_reg_addr_o(cm_reg_addr), .cm_reg_data_o(cm_reg_data),
    .cm_st_we_o(cm_st_we), .cm_st_addr_o(cm_st_addr), .cm_st_data_o(cm_st_data),
    .flush_o(flush), .redirect_o(redirect), .exc_o(exc)
  );

  int checks = 0, errors = 0;
  // expected event kinds: 0 reg write, 1 store, 2 flush, 3 exception
  int    q_kind[$], q_addr[$], q_data[$];
  string q_req[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic expect_ev(input int k, input int a, input int d, input string req);
    q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d); q_req.push_back(req);
  endtask

  task automatic got(input int k, input int a, input int d);
    checks++;
    if (q_kind.size() == 0) begin
      errors++;
      $display("FAIL R4/R8 unexpected event: actual kind=%0d addr=%0h data=%0h expected none", k, a, d);
    end else begin
      int ek, ea, ed; string er;
      ek = q_kind.pop_front(); ea = q_addr.pop_front(); ed = q_data.pop_front(); er = q_req.pop_front();
      if (ek != k || ea != a || ed != d) begin
        errors++;
        $display("FAIL %s: actual kind=%0d addr=%0h data=%0h expected kind=%0d addr=%0h data=%0h",
                 er, k, a, d, ek, ea, ed);
      end
    end
  endtask

  // monitor
  always begin
    @(negedge clk); #3;
    if (rst_n) begin
      for (int s = 0; s < 2; s++) begin
        if (cm_reg_we[s]) got(0, int'(cm_reg_addr[s]), int'(cm_reg_data[s]));
        if (cm_st_we[s])  got(1, int'(cm_st_addr[s]), int'(cm_st_data[s]));
      end
      if (flush) got(2, 0, int'(redirect));
      if (exc)   got(3, 0, 0);
    end
  end

  task automatic do_alloc(input int kind, input int dest, input int exp_tag, input string req);
    @(negedge clk); #1;
    alloc_req = 1; alloc_kind = 2'(kind); alloc_dest = DEST_W'(dest);
    #1 check(alloc_gnt && alloc_tag == TAG_W'(exp_tag), req, {alloc_gnt, alloc_tag}, {1'b1, TAG_W'(exp_tag)});
    @(posedge clk); #1 alloc_req = 0;
  endtask

  task automatic do_res(input int tag, input int val, input bit e);
    @(negedge clk); #1;
    res_valid = 1; res_tag = TAG_W'(tag); res_value = DATA_W'(val); res_exc = e;
    @(posedge clk); #1 res_valid = 0; res_exc = 0;
  endtask

  task automatic do_br(input int tag, input bit mis, input int tgt);
    @(negedge clk); #1;
    br_valid = 1; br_tag = TAG_W'(tag); br_mispred = mis; br_target = DATA_W'(tgt);
    @(posedge clk); #1 br_valid = 0; br_mispred = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20 rst_n = 1;
    @(negedge clk); #2;
    // R1 reset state
    look_tag = 0; src_reg = 3;
    #1 check(alloc_gnt && alloc_tag == 0 && cm_reg_we == 0 && cm_st_we == 0 && !flush && !exc
             && !look_ready && !src_busy, "R1", {alloc_gnt, alloc_tag, look_ready, src_busy}, 4'b1000);

    // R2 sequential tags
    do_alloc(0, 3, 0, "R2");
    do_alloc(1, 16'h40, 1, "R2");
    do_alloc(0, 5, 2, "R2");
    #1 check(src_busy && src_tag == 0, "R9 mark set", {src_busy, src_tag}, 4'b1000);

    // R3 lookup before/after result, R4 no retire while head waits
    look_tag = 2;
    #1 check(!look_ready, "R3 not ready", look_ready, 0);
    do_res(2, 32'h22, 0);
    #1 check(look_ready && look_value == 32'h22, "R3", look_value, 32'h22);
    do_res(1, 32'h11, 0);
    idle(2); #3;
    check(cm_reg_we == 0 && cm_st_we == 0, "R4", {cm_reg_we, cm_st_we}, 0);

    // R5/R6 two retire in one cycle
    expect_ev(0, 3, 32'hAA, "R5 reg write");
    expect_ev(1, 16'h40, 32'h11, "R5 store");
    expect_ev(0, 5, 32'h22, "R5 reg write 2");
    do_res(0, 32'hAA, 0);
    @(negedge clk); #3;
    check(cm_reg_we[0] && cm_st_we[1], "R6 dual retire", {cm_reg_we, cm_st_we}, 4'b0110);
    idle(2);
    src_reg = 3;
    #1 check(!src_busy, "R9 mark cleared", src_busy, 0);

    // R9 clear only if mark names retiring tag
    do_alloc(0, 4, 3, "R2");
    do_alloc(0, 4, 4, "R2");
    src_reg = 4;
    #1 check(src_busy && src_tag == 4, "R9 youngest", {src_busy, src_tag}, 4'b1100);
    expect_ev(0, 4, 32'h33, "R5");
    do_res(3, 32'h33, 0);
    idle(2);
    #1 check(src_busy && src_tag == 4, "R9 kept", {src_busy, src_tag}, 4'b1100);
    expect_ev(0, 4, 32'h44, "R5");
    do_res(4, 32'h44, 0);
    idle(2);
    #1 check(!src_busy, "R9 cleared", src_busy, 0);

    // R10 result to a free entry ignored
    do_res(6, 32'h99, 0);
    look_tag = 6;
    #1 check(!look_ready, "R10", look_ready, 0);

    // fill with wrap, R2
    do_alloc(2, 0, 5, "R2 branch");
    do_alloc(0, 1, 6, "R2");
    #1 check(!look_ready, "R10 stale", look_ready, 0);
    do_alloc(0, 2, 7, "R2");
    for (int t = 0; t < 5; t++) do_alloc(0, 6, t, "R2 wrap");
    @(negedge clk); #1 alloc_req = 1;
    #1 check(!alloc_gnt, "R2 full refuse", alloc_gnt, 0);
    @(posedge clk); #1 alloc_req = 0;

    // R8 deferred exception
    do_res(7, 32'h77, 1);
    idle(3);
    look_tag = 7;
    #1 check(look_ready && look_value == 32'h77, "R3 held", look_value, 32'h77);
    do_br(5, 0, 0);
    idle(2);
    expect_ev(0, 1, 32'h61, "R6 slot0 before exc");
    expect_ev(3, 0, 0, "R8 exception");
    do_res(6, 32'h61, 0);
    idle(3);
    src_reg = 6;
    #1 check(!src_busy, "R9 flush clears", src_busy, 0);
    do_alloc(2, 0, 0, "R8 restart tag");

    // R7 mispredict flush, discarded exception R8
    do_alloc(0, 2, 1, "R2");
    do_alloc(1, 16'h80, 2, "R2");
    do_res(1, 32'h5, 1);
    do_res(2, 32'h6, 0);
    idle(2);
    expect_ev(2, 0, 32'h1234, "R7 flush");
    do_br(0, 1, 32'h1234);
    idle(3);
    do_alloc(1, 16'h90, 0, "R7 restart tag");

    // R6 slot1 blocked by mispredict
    do_alloc(2, 0, 1, "R2");
    do_br(1, 1, 32'h4000);
    idle(2);
    expect_ev(1, 16'h90, 32'hBEEF, "R6 store");
    expect_ev(2, 0, 32'h4000, "R6 flush after");
    do_res(0, 32'hBEEF, 0);
    idle(4);
    check(q_kind.size() == 0, "R8 all events seen", q_kind.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule